// File: doc/BRIEF.md
# MSI-X Request Validator

This block sits between application logic that wants to raise MSI-X interrupts and the logic that builds the posted-write packet. The requester supplies the 64-bit message address, 32-bit message data and a 3-bit traffic class. It tags each request with a physical function number, a flag saying whether the source is a virtual function, and an 11-bit virtual function offset. The block does not look up any message table.

When a request is accepted, the block checks it against per-function configuration inputs: the MSI-X enable bit, the function mask bit, the number of virtual functions attached, and the routing offset of the first virtual function. One cycle later it returns a single-cycle acknowledge together with one error bit. If the request passes every check, it emits a descriptor in that same cycle. The descriptor carries the address, data, traffic class and a computed 16-bit requester ID.

Top module: `msixv_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ack`, `ack_err` and `dsc_valid` are 0.
- R2: A request is accepted on a clock edge where `req` is high and was low at the previous edge (the state held through reset counts as high). `ack` is high for exactly the one cycle that follows that edge.
- R3: While `req` stays high after acceptance, no further `ack` is produced. A new request needs `req` low for at least one clock edge.
- R4: A physical function number of `NUM_PF` or more yields `ack_err` = 1 and no descriptor.
- R5: A function whose `cfg_msix_en` bit is 0 yields `ack_err` = 1 and no descriptor.
- R6: A function whose `cfg_fn_mask` bit is 1 yields `ack_err` = 1 and no descriptor.
- R7: With `req_vf_act` = 1, an offset at or above that function's `cfg_vf_count` field (11 bits per function, function i at bits [11i+10:11i]) yields `ack_err` = 1. A count of 0 rejects every VF request.
- R8: A request that passes all checks yields `ack_err` = 0 and `dsc_valid` = 1 in the `ack` cycle. `dsc_addr`, `dsc_data` and `dsc_tc` equal the values on the request inputs at acceptance.
- R9: The descriptor requester ID is the PF number for a PF request. For a VF request it is PF number + `cfg_first_vf` field (16 bits per function, function i at bits [16i+15:16i]) + offset, modulo 2^16. `dsc_vf` equals `req_vf_act`.
- R10: `dsc_valid` is high only in an `ack` cycle with `ack_err` = 0.
- R11: With `req_vf_act` = 0, the offset input has no effect on the outcome or the requester ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Interrupt request level |
| req_pf | input | PF_W | Physical function number |
| req_vf_act | input | 1 | Request originates from a virtual function |
| req_vf_off | input | 11 | Virtual function offset under the PF |
| req_addr | input | 64 | Message address |
| req_data | input | 32 | Message data |
| req_tc | input | 3 | Traffic class |
| cfg_msix_en | input | NUM_PF | Per-function MSI-X enable |
| cfg_fn_mask | input | NUM_PF | Per-function mask |
| cfg_vf_count | input | NUM_PF*11 | Per-function attached VF count |
| cfg_first_vf | input | NUM_PF*16 | Per-function first-VF routing offset |
| ack | output | 1 | Acknowledge pulse |
| ack_err | output | 1 | 1: rejected, no message; valid with ack |
| dsc_valid | output | 1 | Descriptor valid pulse |
| dsc_addr | output | 64 | Descriptor address |
| dsc_data | output | 32 | Descriptor data |
| dsc_tc | output | 3 | Descriptor traffic class |
| dsc_rid | output | 16 | Descriptor requester ID |
| dsc_vf | output | 1 | Descriptor is from a VF |

## Verification
The hardest situation to reach is a request held high for many cycles and then raised again after exactly one low cycle. The held phase must produce no extra acknowledge, and the one-cycle gap must be enough for a second acceptance. The stimulus holds requests for varying lengths and always returns with the minimum gap. The VF checks are driven at the count boundary: offset equal to count minus one, offset equal to count, and a count of zero. The requester ID addition is pushed through the 16-bit wrap with a first-VF offset near the top of its range.

// File: rtl/msixv_pkg.sv
package msixv_pkg;

    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;
    localparam int TC_W   = 3;
    localparam int VF_W   = 11;
    localparam int RID_W  = 16;

    typedef enum logic [2:0] {
        REJ_NONE,
        REJ_BAD_PF,
        REJ_DISABLED,
        REJ_MASKED,
        REJ_VF_RANGE
    } rej_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TC_W-1:0]   tc;
        logic [RID_W-1:0]  rid;
        logic              vf;
    } msix_desc_t;

    function automatic logic [RID_W-1:0] make_rid(
        input logic [RID_W-1:0] pf_rid,
        input logic             is_vf,
        input logic [RID_W-1:0] first_vf,
        input logic [VF_W-1:0]  vf_off
    );
        logic [RID_W-1:0] r;
        if (is_vf) r = pf_rid + first_vf + RID_W'(vf_off);
        else       r = pf_rid;
        return r;
    endfunction

endpackage

// File: rtl/msixv_edge.sv
module msixv_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic accept
);
    logic req_prev;

    always_ff @(posedge clk) begin
        if (rst) req_prev <= 1'b1;
        else     req_prev <= req;
    end

    assign accept = req && !req_prev && !rst;
endmodule

// File: rtl/msixv_fnsel.sv
module msixv_fnsel
    import msixv_pkg::*;
#(
    parameter int NUM_PF = 3,
    parameter int PF_W   = 2
) (
    input  logic [PF_W-1:0]         pf,
    input  logic [NUM_PF-1:0]       cfg_msix_en,
    input  logic [NUM_PF-1:0]       cfg_fn_mask,
    input  logic [NUM_PF*VF_W-1:0]  cfg_vf_count,
    input  logic [NUM_PF*RID_W-1:0] cfg_first_vf,
    output logic                    pf_ok,
    output logic                    sel_en,
    output logic                    sel_mask,
    output logic [VF_W-1:0]         sel_vf_cnt,
    output logic [RID_W-1:0]        sel_first
);
    logic [NUM_PF-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_PF; g++) begin : g_hit
            assign hit[g] = (pf == PF_W'(g));
        end
    endgenerate

    always_comb begin
        pf_ok      = |hit;
        sel_en     = |(hit & cfg_msix_en);
        sel_mask   = |(hit & cfg_fn_mask);
        sel_vf_cnt = '0;
        sel_first  = '0;
        for (int i = 0; i < NUM_PF; i++) begin
            sel_vf_cnt = sel_vf_cnt | ({VF_W{hit[i]}}  & cfg_vf_count[i*VF_W +: VF_W]);
            sel_first  = sel_first  | ({RID_W{hit[i]}} & cfg_first_vf[i*RID_W +: RID_W]);
        end
    end
endmodule

// File: rtl/msixv_judge.sv
module msixv_judge
    import msixv_pkg::*;
(
    input  logic            pf_ok,
    input  logic            sel_en,
    input  logic            sel_mask,
    input  logic [VF_W-1:0] sel_vf_cnt,
    input  logic            vf_act,
    input  logic [VF_W-1:0] vf_off,
    output rej_e            verdict
);
    always_comb begin
        if (!pf_ok)                             verdict = REJ_BAD_PF;
        else if (!sel_en)                       verdict = REJ_DISABLED;
        else if (sel_mask)                      verdict = REJ_MASKED;
        else if (vf_act && vf_off >= sel_vf_cnt) verdict = REJ_VF_RANGE;
        else                                    verdict = REJ_NONE;
    end
endmodule

// File: rtl/msixv_top.sv
module msixv_top
    import msixv_pkg::*;
#(
    parameter int NUM_PF = 3,
    parameter int PF_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic [PF_W-1:0]         req_pf,
    input  logic                    req_vf_act,
    input  logic [VF_W-1:0]         req_vf_off,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_data,
    input  logic [TC_W-1:0]         req_tc,
    input  logic [NUM_PF-1:0]       cfg_msix_en,
    input  logic [NUM_PF-1:0]       cfg_fn_mask,
    input  logic [NUM_PF*VF_W-1:0]  cfg_vf_count,
    input  logic [NUM_PF*RID_W-1:0] cfg_first_vf,
    output logic                    ack,
    output logic                    ack_err,
    output logic                    dsc_valid,
    output logic [ADDR_W-1:0]       dsc_addr,
    output logic [DATA_W-1:0]       dsc_data,
    output logic [TC_W-1:0]         dsc_tc,
    output logic [RID_W-1:0]        dsc_rid,
    output logic                    dsc_vf
);
    logic             accept;
    logic             pf_ok;
    logic             sel_en;
    logic             sel_mask;
    logic [VF_W-1:0]  sel_vf_cnt;
    logic [RID_W-1:0] sel_first;
    rej_e             verdict;
    msix_desc_t       nxt_desc;
    msix_desc_t       desc_q;
    logic             ack_q;
    logic             err_q;
    logic             dv_q;

    msixv_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .accept (accept)
    );

    msixv_fnsel #(.NUM_PF(NUM_PF), .PF_W(PF_W)) u_fnsel (
        .pf           (req_pf),
        .cfg_msix_en  (cfg_msix_en),
        .cfg_fn_mask  (cfg_fn_mask),
        .cfg_vf_count (cfg_vf_count),
        .cfg_first_vf (cfg_first_vf),
        .pf_ok        (pf_ok),
        .sel_en       (sel_en),
        .sel_mask     (sel_mask),
        .sel_vf_cnt   (sel_vf_cnt),
        .sel_first    (sel_first)
    );

    msixv_judge u_judge (
        .pf_ok      (pf_ok),
        .sel_en     (sel_en),
        .sel_mask   (sel_mask),
        .sel_vf_cnt (sel_vf_cnt),
        .vf_act     (req_vf_act),
        .vf_off     (req_vf_off),
        .verdict    (verdict)
    );

    always_comb begin
        nxt_desc.addr = req_addr;
        nxt_desc.data = req_data;
        nxt_desc.tc   = req_tc;
        nxt_desc.vf   = req_vf_act;
        nxt_desc.rid  = make_rid(RID_W'(req_pf), req_vf_act, sel_first, req_vf_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            dv_q   <= 1'b0;
            desc_q <= '0;
        end else begin
            ack_q <= accept;
            dv_q  <= accept && (verdict == REJ_NONE);
            if (accept) begin
                err_q <= (verdict != REJ_NONE);
            end
            if (accept && verdict == REJ_NONE) begin
                desc_q <= nxt_desc;
            end
        end
    end

    assign ack       = ack_q;
    assign ack_err   = ack_q && err_q;
    assign dsc_valid = dv_q;
    assign dsc_addr  = desc_q.addr;
    assign dsc_data  = desc_q.data;
    assign dsc_tc    = desc_q.tc;
    assign dsc_rid   = desc_q.rid;
    assign dsc_vf    = desc_q.vf;
endmodule

// File: rtl/msixv_sva.sv
module msixv_sva
    import msixv_pkg::*;
#(
    parameter int NUM_PF = 3,
    parameter int PF_W   = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req,
    input logic [PF_W-1:0]        req_pf,
    input logic                   req_vf_act,
    input logic [VF_W-1:0]        req_vf_off,
    input logic [NUM_PF-1:0]      cfg_msix_en,
    input logic [NUM_PF-1:0]      cfg_fn_mask,
    input logic [NUM_PF*VF_W-1:0] cfg_vf_count,
    input logic                   ack,
    input logic                   ack_err,
    input logic                   dsc_valid,
    input logic [RID_W-1:0]       dsc_rid,
    input logic                   dsc_vf
);
    logic            c_valid;
    logic            c_en;
    logic            c_mask;
    logic [VF_W-1:0] c_cnt;

    always_comb begin
        c_valid = 1'b0;
        c_en    = 1'b0;
        c_mask  = 1'b0;
        c_cnt   = '0;
        for (int i = 0; i < NUM_PF; i++) begin
            if (req_pf == PF_W'(i)) begin
                c_valid = 1'b1;
                c_en    = cfg_msix_en[i];
                c_mask  = cfg_fn_mask[i];
                c_cnt   = cfg_vf_count[i*VF_W +: VF_W];
            end
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R2
    AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(req)); // R2
    AST_HELD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (req && $past(req)) |=> !ack); // R3
    AST_BAD_PF: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(!c_valid)) |-> ack_err); // R4
    AST_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(c_valid && !c_en)) |-> ack_err); // R5
    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(c_mask)) |-> ack_err); // R6
    AST_VF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(req_vf_act && req_vf_off >= c_cnt)) |-> ack_err); // R7
    AST_OK_DESC: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_err) |-> dsc_valid); // R8
    AST_PF_RID: assert property (@(posedge clk) disable iff (rst)
        (dsc_valid && !dsc_vf) |-> dsc_rid == RID_W'($past(req_pf))); // R9
    AST_DESC_GATED: assert property (@(posedge clk) disable iff (rst)
        dsc_valid |-> (ack && !ack_err)); // R10
endmodule

bind msixv_top msixv_sva #(.NUM_PF(NUM_PF), .PF_W(PF_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_pf       (req_pf),
    .req_vf_act   (req_vf_act),
    .req_vf_off   (req_vf_off),
    .cfg_msix_en  (cfg_msix_en),
    .cfg_fn_mask  (cfg_fn_mask),
    .cfg_vf_count (cfg_vf_count),
    .ack          (ack),
    .ack_err      (ack_err),
    .dsc_valid    (dsc_valid),
    .dsc_rid      (dsc_rid),
    .dsc_vf       (dsc_vf)
);

// File: tb/msixv_top_tb.sv
`timescale 1ns/1ps
module msixv_top_tb;
    localparam int NPF = 3;
    localparam int PFW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [PFW-1:0]    req_pf = '0;
    logic              req_vf_act = 1'b0;
    logic [10:0]       req_vf_off = '0;
    logic [63:0]       req_addr = '0;
    logic [31:0]       req_data = '0;
    logic [2:0]        req_tc = '0;
    logic [NPF-1:0]    cfg_msix_en = '0;
    logic [NPF-1:0]    cfg_fn_mask = '0;
    logic [NPF*11-1:0] cfg_vf_count = '0;
    logic [NPF*16-1:0] cfg_first_vf = '0;
    logic              ack, ack_err, dsc_valid, dsc_vf;
    logic [63:0]       dsc_addr;
    logic [31:0]       dsc_data;
    logic [2:0]        dsc_tc;
    logic [15:0]       dsc_rid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    msixv_top #(.NUM_PF(NPF), .PF_W(PFW)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_pf(req_pf),
        .req_vf_act(req_vf_act), .req_vf_off(req_vf_off),
        .req_addr(req_addr), .req_data(req_data), .req_tc(req_tc),
        .cfg_msix_en(cfg_msix_en), .cfg_fn_mask(cfg_fn_mask),
        .cfg_vf_count(cfg_vf_count), .cfg_first_vf(cfg_first_vf),
        .ack(ack), .ack_err(ack_err), .dsc_valid(dsc_valid),
        .dsc_addr(dsc_addr), .dsc_data(dsc_data), .dsc_tc(dsc_tc),
        .dsc_rid(dsc_rid), .dsc_vf(dsc_vf)
    );

    // behavioural reference model
    bit          m_prev = 1;
    bit          m_rst_seen = 1;
    bit          e_ack = 0, e_err = 0, e_dv = 0, e_vf = 0;
    logic [63:0] e_addr = '0;
    logic [31:0] e_data = '0;
    logic [2:0]  e_tc = '0;
    logic [15:0] e_rid = '0;
    string       e_tag = "R1";
    string       rid_tag = "R9";

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 1; e_ack = 0; e_err = 0; e_dv = 0; e_tag = "R1"; m_rst_seen = 1;
        end else begin
            int  pf;
            int  cnt;
            int  first;
            bit  acc;
            pf  = int'(req_pf);
            acc = req && !m_prev;
            m_prev = req;
            e_ack = acc;
            e_tag = m_rst_seen ? "R1" : "R2";
            m_rst_seen = 0;
            e_dv = 0;
            if (acc) begin
                e_err = 1;
                if (pf >= NPF) e_tag = "R4";
                else begin
                    cnt   = int'(cfg_vf_count[pf*11 +: 11]);
                    first = int'(cfg_first_vf[pf*16 +: 16]);
                    if (!cfg_msix_en[pf])                          e_tag = "R5";
                    else if (cfg_fn_mask[pf])                      e_tag = "R6";
                    else if (req_vf_act && int'(req_vf_off) >= cnt) e_tag = "R7";
                    else begin
                        e_tag = "R8"; e_err = 0; e_dv = 1;
                        e_addr = req_addr; e_data = req_data; e_tc = req_tc;
                        e_vf = req_vf_act;
                        if (req_vf_act) begin
                            e_rid = 16'((pf + first + int'(req_vf_off)) % 65536);
                            rid_tag = "R9";
                        end else begin
                            e_rid = 16'(pf);
                            rid_tag = "R11";
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(e_ack ? e_tag : "R3", "ack", 64'(ack), 64'(e_ack));
            chk("R10", "dsc_valid", 64'(dsc_valid), 64'(e_dv));
            if (e_ack) chk(e_tag, "ack_err", 64'(ack_err), 64'(e_err));
            if (e_dv) begin
                chk("R8", "addr", dsc_addr, e_addr);
                chk("R8", "data", 64'(dsc_data), 64'(e_data));
                chk("R8", "tc", 64'(dsc_tc), 64'(e_tc));
                chk(rid_tag, "rid", 64'(dsc_rid), 64'(e_rid));
                chk("R9", "vf", 64'(dsc_vf), 64'(e_vf));
            end
        end
    end

    task automatic scramble();
        req_addr   = {$urandom, $urandom};
        req_data   = $urandom;
        req_tc     = 3'($urandom);
        req_vf_off = 11'($urandom);
        req_pf     = PFW'($urandom);
        req_vf_act = 1'($urandom);
    endtask

    task automatic send(input int pf, input bit vfa, input int off, input int hold);
        @(negedge clk);
        scramble();
        req_pf = PFW'(pf); req_vf_act = vfa; req_vf_off = 11'(off);
        req = 1'b1;
        repeat (hold) @(negedge clk);
        req = 1'b0;
        scramble();
    endtask

    task automatic set_pf(input int pf, input bit en, input bit msk,
                          input int cnt, input int first);
        cfg_msix_en[pf]          = en;
        cfg_fn_mask[pf]          = msk;
        cfg_vf_count[pf*11 +: 11] = 11'(cnt);
        cfg_first_vf[pf*16 +: 16] = 16'(first);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=finish");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in and right after reset, request held high through reset
        req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "ack in reset", 64'(ack), 64'd0);
        chk("R1", "dsc_valid in reset", 64'(dsc_valid), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        req = 1'b0;
        set_pf(0, 1, 0, 4, 16'h0100);
        set_pf(1, 1, 0, 0, 16'h0200);
        set_pf(2, 1, 0, 2047, 16'hFFFF);
        @(negedge clk);

        send(0, 0, 0, 1);          // R8 plain PF
        send(1, 0, 5, 1);          // R11 offset ignored for PF
        send(2, 0, 2047, 1);       // R11
        send(3, 0, 0, 1);          // R4 nonexistent PF
        send(3, 1, 0, 2);          // R4
        send(0, 1, 3, 1);          // R7 last legal VF
        send(0, 1, 4, 1);          // R7 first illegal VF
        send(1, 1, 0, 1);          // R7 count zero
        send(2, 1, 2046, 1);       // R9 RID wrap
        send(2, 1, 5, 6);          // R3 held request
        send(0, 0, 0, 4);          // R3
        set_pf(1, 0, 0, 8, 0);
        send(1, 0, 0, 1);          // R5 disabled
        set_pf(1, 1, 1, 8, 0);
        send(1, 1, 2, 1);          // R6 masked
        set_pf(1, 1, 0, 8, 16'h0040);
        send(1, 1, 7, 1);          // R9 VF in range

        for (int n = 0; n < 400; n++) begin
            if (n % 8 == 0) begin
                for (int p = 0; p < NPF; p++)
                    set_pf(p, ($urandom % 4) != 0, ($urandom % 5) == 0,
                           int'($urandom % 10), int'($urandom % 65536));
            end
            send(int'($urandom % 4), 1'($urandom), int'($urandom % 12),
                 1 + int'($urandom % 3));
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule